// File: doc/BRIEF.md
# Inbound Address Window Decoder

This unit decides where an inbound bus address goes. It holds a small set of programmable address windows and one aperture register pair that gates the whole inbound space. An address is served only when it lies inside the enabled aperture and inside at least one enabled window. The lowest-numbered matching window then supplies a target identifier, an attribute byte and a remapped address. All other addresses are reported as errors with a fixed "no target" code.

Software programs the windows through a simple register port: one write strobe, one read strobe and a byte offset. Each window takes sixteen bytes of register space, holding a control word, a base word and a remap word. The aperture occupies the slot after the last window. The address lookup takes one registered cycle. A request presented with `in_valid` at one rising edge produces its result, flagged by `out_valid`, at that same edge, and the result can be sampled in the following cycle.

Window sizes are powers of two at 64 KB granularity. The aperture size field written by software is widened by hardware to the next covering power of two.

Top module: `inb_win_decode`

## Requirements
- R1: After reset every window and the aperture are disabled, every register reads 0, `out_valid` is 0, and any lookup reports a miss.
- R2: A window control word reads back with its fields at these positions: size-minus-one in bits 31:16, attribute in bits 15:8, target in bits 7:4 and enable in bit 0. Bits 3:1 always read 0.
- R3: The window base word and remap word keep only bits 31:16. Bits 15:0 read 0, which gives 64 KB granularity.
- R4: A window with mask M (size-minus-one) and base B matches address A when it is enabled and (A[31:16] & ~M) == B. A base with bits set inside M never matches. When a lookup hits, `out_hit`=1, `out_err`=0, and `out_tgt` and `out_attr` come from the chosen window.
- R5: When several enabled windows match, the one with the lowest index wins.
- R6: On a hit, `out_addr` = {(remap & ~M) | (A[31:16] & M), A[15:0]}.
- R7: A lookup misses whenever the aperture is disabled or A[31:16] & ~apt_mask differs from apt_base, even if a window matches.
- R8: The aperture size register sits at offset NUM_WIN*16+4, with size-minus-one in bits 31:16 and enable in bit 0. A written size field is stored as the smallest value of the form 2^k-1 that covers it (every bit below its highest set bit is filled). All other bits read 0.
- R9: The aperture base register sits at offset NUM_WIN*16 and keeps bits 31:16. Once it has been written, bits 3:0 read 0xC (64-bit, prefetchable) and bits 15:4 read 0.
- R10: A miss drives `out_hit`=0, `out_err`=1, `out_tgt`=0xF, `out_attr`=0 and `out_addr`=0.
- R11: `out_valid` follows `in_valid` with one cycle of latency. When `in_valid` is low, the result outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe; data appears on `cfg_rdata` after the edge |
| cfg_addr | input | REG_AW | Register byte offset (window w at w*16: +0 control, +4 base, +8 remap) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 32 | Address to decode |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Address decoded to a window |
| out_err | output | 1 | Address not served |
| out_tgt | output | 4 | Target identifier, 0xF on miss |
| out_attr | output | 8 | Attribute byte of the chosen window |
| out_addr | output | 32 | Translated address |

## Verification
A corrupted mask, base or enable bit inside a window shows up at the very next lookup that falls in or near that window. The result is a wrong target, a wrong translated address, or a spurious error, so directed addresses are placed on window edges and on overlaps. A faulty priority choice appears only when enabled windows overlap, so both the directed and the random stimulus deliberately overlap them. Aperture rounding and the base tag are visible only through the register readback one cycle after the read strobe, and through which addresses are refused at the next lookup.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;

   localparam int unsigned ADDR_W   = 32;
   localparam int unsigned HI_W     = 16;
   localparam int unsigned ATTR_W   = 8;
   localparam int unsigned TGT_W    = 4;

   localparam logic [TGT_W-1:0] MISS_TGT   = 4'hF;
   localparam logic [3:0]       APT_LO_TAG = 4'hC;

   // register selector inside one 16-byte slot
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_REMAP = 2'd2,
      SEL_NONE  = 2'd3
   } slot_sel_e;

   typedef struct packed {
      logic [HI_W-1:0]   mask;
      logic [HI_W-1:0]   base;
      logic [HI_W-1:0]   remap;
      logic [ATTR_W-1:0] attr;
      logic [TGT_W-1:0]  tgt;
      logic              en;
   } win_cfg_t;

   // fill every bit below the highest set bit
   function automatic logic [HI_W-1:0] fill_below_msb(input logic [HI_W-1:0] v);
      logic [HI_W-1:0] r;
      r = v;
      for (int s = 1; s < int'(HI_W); s = s * 2) begin
         r = r | (r >> s);
      end
      return r;
   endfunction

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
   import inb_win_pkg::*;
#(
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned REG_AW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output win_cfg_t          win_cfg [NUM_WIN],
   output logic              apt_en,
   output logic [HI_W-1:0]   apt_base,
   output logic [HI_W-1:0]   apt_mask
);

   localparam int unsigned SLOT_W = REG_AW - 4;
   localparam logic [SLOT_W-1:0] APT_SLOT = SLOT_W'(NUM_WIN);

   logic [SLOT_W-1:0] slot;
   slot_sel_e         sel;
   logic              addr_lsb_unused;
   logic              apt_tag_q;
   logic [31:0]       rd_mux;

   assign slot            = cfg_addr[REG_AW-1:4];
   assign sel             = slot_sel_e'(cfg_addr[3:2]);
   assign addr_lsb_unused = ^cfg_addr[1:0];

   for (genvar w = 0; w < int'(NUM_WIN); w++) begin : g_win
      win_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (cfg_wr && slot == SLOT_W'(w)) begin
            case (sel)
               SEL_CTRL: begin
                  q.mask <= cfg_wdata[31:16];
                  q.attr <= cfg_wdata[15:8];
                  q.tgt  <= cfg_wdata[7:4];
                  q.en   <= cfg_wdata[0];
               end
               SEL_BASE:  q.base  <= cfg_wdata[31:16];
               SEL_REMAP: q.remap <= cfg_wdata[31:16];
               default: ;
            endcase
         end
      end
      assign win_cfg[w] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         apt_en    <= 1'b0;
         apt_base  <= '0;
         apt_mask  <= '0;
         apt_tag_q <= 1'b0;
      end else if (cfg_wr && slot == APT_SLOT) begin
         case (sel)
            SEL_CTRL: begin
               apt_base  <= cfg_wdata[31:16];
               apt_tag_q <= 1'b1;
            end
            SEL_BASE: begin
               apt_mask <= fill_below_msb(cfg_wdata[31:16]);
               apt_en   <= cfg_wdata[0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int w = 0; w < int'(NUM_WIN); w++) begin
         if (slot == SLOT_W'(w)) begin
            case (sel)
               SEL_CTRL:  rd_mux = {win_cfg[w].mask, win_cfg[w].attr,
                                    win_cfg[w].tgt, 3'b000, win_cfg[w].en};
               SEL_BASE:  rd_mux = {win_cfg[w].base, 16'h0000};
               SEL_REMAP: rd_mux = {win_cfg[w].remap, 16'h0000};
               default:   rd_mux = '0;
            endcase
         end
      end
      if (slot == APT_SLOT) begin
         case (sel)
            SEL_CTRL: rd_mux = {apt_base, 12'h000, apt_tag_q ? APT_LO_TAG : 4'h0};
            SEL_BASE: rd_mux = {apt_mask, 15'h0000, apt_en};
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
      end else if (cfg_rd) begin
         cfg_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match
   import inb_win_pkg::*;
(
   input  logic            en,
   input  logic [HI_W-1:0] base,
   input  logic [HI_W-1:0] mask,
   input  logic [HI_W-1:0] addr_hi,
   output logic            hit
);

   assign hit = en && ((addr_hi & ~mask) == base);

endmodule

// File: rtl/inb_win_pick.sv
module inb_win_pick #(
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_WIN-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   assign any = |req;

   if (NUM_WIN == 1) begin : g_single
      assign idx = '0;
   end else begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = int'(NUM_WIN) - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/inb_win_decode.sv
module inb_win_decode
   import inb_win_pkg::*;
#(
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned REG_AW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic              out_hit,
   output logic              out_err,
   output logic [TGT_W-1:0]  out_tgt,
   output logic [ATTR_W-1:0] out_attr,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (REG_AW < 5 || NUM_WIN < 1 || NUM_WIN >= (1 << (REG_AW - 4))) begin : g_bad_cfg
      $error("inb_win_decode: windows plus aperture do not fit the register space");
   end

   win_cfg_t            win_cfg [NUM_WIN];
   logic                apt_en;
   logic [HI_W-1:0]     apt_base;
   logic [HI_W-1:0]     apt_mask;
   logic                apt_hit;
   logic [NUM_WIN-1:0]  win_hit;
   logic                win_any;
   logic [IDX_W-1:0]    win_idx;
   logic [HI_W-1:0]     addr_hi;
   logic [HI_W-1:0]     pick_mask;
   logic [HI_W-1:0]     pick_remap;
   logic [HI_W-1:0]     xlat_hi;
   logic                served;

   assign addr_hi = in_addr[ADDR_W-1:ADDR_W-HI_W];

   inb_win_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_rd    (cfg_rd),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .win_cfg   (win_cfg),
      .apt_en    (apt_en),
      .apt_base  (apt_base),
      .apt_mask  (apt_mask)
   );

   for (genvar w = 0; w < int'(NUM_WIN); w++) begin : g_match
      inb_win_match u_match (
         .en      (win_cfg[w].en),
         .base    (win_cfg[w].base),
         .mask    (win_cfg[w].mask),
         .addr_hi (addr_hi),
         .hit     (win_hit[w])
      );
   end

   inb_win_match u_apt_match (
      .en      (apt_en),
      .base    (apt_base),
      .mask    (apt_mask),
      .addr_hi (addr_hi),
      .hit     (apt_hit)
   );

   inb_win_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
      .req (win_hit),
      .any (win_any),
      .idx (win_idx)
   );

   assign pick_mask  = win_cfg[win_idx].mask;
   assign pick_remap = win_cfg[win_idx].remap;
   assign xlat_hi    = (pick_remap & ~pick_mask) | (addr_hi & pick_mask);
   assign served     = apt_hit && win_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_err   <= 1'b0;
         out_tgt   <= '0;
         out_attr  <= '0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            if (served) begin
               out_hit  <= 1'b1;
               out_err  <= 1'b0;
               out_tgt  <= win_cfg[win_idx].tgt;
               out_attr <= win_cfg[win_idx].attr;
               out_addr <= {xlat_hi, in_addr[ADDR_W-HI_W-1:0]};
            end else begin
               out_hit  <= 1'b0;
               out_err  <= 1'b1;
               out_tgt  <= MISS_TGT;
               out_attr <= '0;
               out_addr <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/inb_win_checker.sv
module inb_win_checker
   import inb_win_pkg::*;
#(
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned REG_AW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_rd,
   input logic [REG_AW-1:0] cfg_addr,
   input logic [31:0]       cfg_rdata,
   input logic              in_valid,
   input logic              apt_en,
   input logic              out_valid,
   input logic              out_hit,
   input logic              out_err,
   input logic [TGT_W-1:0]  out_tgt,
   input logic [ATTR_W-1:0] out_attr,
   input logic [ADDR_W-1:0] out_addr
);

   localparam int unsigned WA_W = REG_AW - 2;
   localparam logic [WA_W-1:0] APT_LO_WA   = WA_W'(NUM_WIN * 4);
   localparam logic [WA_W-1:0] APT_SIZE_WA = WA_W'(NUM_WIN * 4 + 1);
   localparam logic [WA_W-1:0] WIN_END_WA  = WA_W'(NUM_WIN * 4);

   logic [WA_W-1:0] wa;
   assign wa = cfg_addr[REG_AW-1:2];

   assert_miss_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (out_err && out_tgt == MISS_TGT &&
                                   out_attr == '0 && out_addr == '0));

   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_tgt) && $stable(out_addr) &&
                     $stable(out_hit)));

   assert_apt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !apt_en) |=> (out_err && !out_hit));

   assert_apt_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && wa == APT_SIZE_WA) |=>
         (((cfg_rdata[31:16] & (cfg_rdata[31:16] + 16'd1)) == 16'd0) &&
          cfg_rdata[15:1] == 15'd0));

   assert_apt_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && wa == APT_LO_WA) |=>
         (cfg_rdata[15:4] == 12'd0 &&
          (cfg_rdata[3:0] == APT_LO_TAG || cfg_rdata[3:0] == 4'h0)));

   assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && wa < WIN_END_WA && wa[1:0] == 2'd0) |=> (cfg_rdata[3:1] == 3'd0));

endmodule

bind inb_win_decode inb_win_checker #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rd    (cfg_rd),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .in_valid  (in_valid),
   .apt_en    (apt_en),
   .out_valid (out_valid),
   .out_hit   (out_hit),
   .out_err   (out_err),
   .out_tgt   (out_tgt),
   .out_attr  (out_attr),
   .out_addr  (out_addr)
);

// File: tb/test_inb_win_decode.sv
`timescale 1ns/1ps
module test_inb_win_decode;

   localparam int NW = 6;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_rd = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          in_valid = 1'b0;
   logic [31:0]   in_addr = '0;
   logic          out_valid, out_hit, out_err;
   logic [3:0]    out_tgt;
   logic [7:0]    out_attr;
   logic [31:0]   out_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model
   logic [15:0] m_mask [NW];
   logic [15:0] m_base [NW];
   logic [15:0] m_remap[NW];
   logic [7:0]  m_attr [NW];
   logic [3:0]  m_tgt  [NW];
   logic        m_en   [NW];
   logic [15:0] a_base, a_mask;
   logic        a_en;

   always #5 clk = ~clk;

   inb_win_decode #(.NUM_WIN(NW), .REG_AW(AW)) i_inb_win_decode (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
      .out_hit(out_hit), .out_err(out_err), .out_tgt(out_tgt),
      .out_attr(out_attr), .out_addr(out_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = a;
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   // smallest 2^k-1 covering v, found by scanning for the top bit
   function automatic logic [15:0] cover_pow2(input logic [15:0] v);
      int top;
      top = -1;
      for (int i = 0; i < 16; i++) if (v[i]) top = i;
      if (top < 0) return 16'h0;
      return 16'((32'd1 << (top + 1)) - 32'd1);
   endfunction

   task automatic set_win(input int w, input logic [15:0] mask, input logic [15:0] base,
                          input logic [15:0] remap, input logic [7:0] attr,
                          input logic [3:0] tgt, input logic en);
      wr(AW'(w * 16),     {mask, attr, tgt, 3'b000, en});
      wr(AW'(w * 16 + 4), {base, 16'h0});
      wr(AW'(w * 16 + 8), {remap, 16'h0});
      m_mask[w] = mask; m_base[w] = base; m_remap[w] = remap;
      m_attr[w] = attr; m_tgt[w] = tgt; m_en[w] = en;
   endtask

   task automatic set_apt(input logic [15:0] base, input logic [15:0] size, input logic en);
      wr(AW'(NW * 16),     {base, 16'h0});
      wr(AW'(NW * 16 + 4), {size, 15'h0, en});
      a_base = base; a_mask = cover_pow2(size); a_en = en;
   endtask

   function automatic logic [63:0] ref_lookup(input logic [31:0] a);
      logic found;
      logic [63:0] r;
      found = 1'b0;
      r = {18'h0, 1'b0, 1'b1, 4'hF, 8'h00, 32'h0};
      if (a_en && ((a[31:16] & ~a_mask) == a_base)) begin
         for (int i = 0; i < NW; i++) begin
            if (!found && m_en[i] && ((a[31:16] & ~m_mask[i]) == m_base[i])) begin
               found = 1'b1;
               r = {18'h0, 1'b1, 1'b0, m_tgt[i], m_attr[i],
                    (m_remap[i] & ~m_mask[i]) | (a[31:16] & m_mask[i]), a[15:0]};
            end
         end
      end
      return r;
   endfunction

   task automatic look(input logic [31:0] a, output logic [63:0] res);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      res = {18'h0, out_hit, out_err, out_tgt, out_attr, out_addr};
   endtask

   task automatic look_chk(input string tag, input logic [31:0] a);
      logic [63:0] res;
      look(a, res);
      chk(tag, res, ref_lookup(a));
   endtask

   function automatic logic [63:0] pack_res(input logic h, input logic e, input logic [3:0] t,
                                            input logic [7:0] at, input logic [31:0] x);
      return {18'h0, h, e, t, at, x};
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] res;
      void'($urandom(32'h1BAD5EED));
      for (int i = 0; i < NW; i++) begin
         m_mask[i] = '0; m_base[i] = '0; m_remap[i] = '0;
         m_attr[i] = '0; m_tgt[i] = '0; m_en[i] = 1'b0;
      end
      a_base = '0; a_mask = '0; a_en = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 out_valid after reset", {63'h0, out_valid}, 64'h0);
      rd(8'h00, d); chk("R1 win0 ctrl reset", {32'h0, d}, 64'h0);
      rd(AW'(NW * 16), d); chk("R1 aperture base reset", {32'h0, d}, 64'h0);
      rd(AW'(NW * 16 + 4), d); chk("R1 aperture size reset", {32'h0, d}, 64'h0);
      look(32'h1234_0000, res);
      chk("R1 R10 lookup after reset misses", res, pack_res(0, 1, 4'hF, 8'h00, 32'h0));

      // R2 / R3 field layout
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d);
      chk("R2 ctrl readback", {32'h0, d}, {32'h0, 32'hFFFF_FFF1});
      wr(8'h04, 32'h1234_5678); rd(8'h04, d);
      chk("R3 base readback", {32'h0, d}, {32'h0, 32'h1234_0000});
      wr(8'h08, 32'hABCD_EF01); rd(8'h08, d);
      chk("R3 remap readback", {32'h0, d}, {32'h0, 32'hABCD_0000});

      set_win(0, 16'h000F, 16'h0010, 16'h0400, 8'hA5, 4'h3, 1'b1);

      // R7 aperture disabled
      look(32'h0012_3456, res);
      chk("R7 aperture disabled blocks hit", res, pack_res(0, 1, 4'hF, 8'h00, 32'h0));

      // R8 rounding
      wr(AW'(NW * 16 + 4), 32'h0100_0001); rd(AW'(NW * 16 + 4), d);
      chk("R8 size 0x0100 rounds to 0x01FF", {32'h0, d}, {32'h0, 32'h01FF_0001});
      wr(AW'(NW * 16 + 4), 32'h003F_FFFE); rd(AW'(NW * 16 + 4), d);
      chk("R8 size 0x003F kept, enable clear", {32'h0, d}, {32'h0, 32'h003F_0000});
      set_apt(16'h0000, 16'h00A0, 1'b1);
      rd(AW'(NW * 16 + 4), d);
      chk("R8 size 0x00A0 rounds to 0x00FF", {32'h0, d}, {32'h0, 32'h00FF_0001});
      rd(AW'(NW * 16), d);
      chk("R9 aperture base tag", {32'h0, d}, {32'h0, 32'h0000_000C});
      wr(AW'(NW * 16), 32'h5A5A_FFFF); rd(AW'(NW * 16), d);
      chk("R9 aperture base keeps high half", {32'h0, d}, {32'h0, 32'h5A5A_000C});
      wr(AW'(NW * 16), 32'h0000_0000);

      // R4 / R6 hit and translation
      look(32'h0012_3456, res);
      chk("R4 R6 window 0 hit", res, pack_res(1, 0, 4'h3, 8'hA5, 32'h0402_3456));

      // R4 misaligned base never matches
      set_win(3, 16'h000F, 16'h0031, 16'h0000, 8'h11, 4'h9, 1'b1);
      look(32'h0031_0000, res);
      chk("R4 misaligned base misses", res, pack_res(0, 1, 4'hF, 8'h00, 32'h0));

      // R5 priority
      set_win(1, 16'h00FF, 16'h0000, 16'h0000, 8'h22, 4'h7, 1'b1);
      look(32'h0012_3456, res);
      chk("R5 lowest index wins", res, pack_res(1, 0, 4'h3, 8'hA5, 32'h0402_3456));
      set_win(0, 16'h000F, 16'h0010, 16'h0400, 8'hA5, 4'h3, 1'b0);
      look(32'h0012_3456, res);
      chk("R5 R6 next window after disable", res, pack_res(1, 0, 4'h7, 8'h22, 32'h0012_3456));

      // R7 outside aperture
      set_win(2, 16'hFFFF, 16'h0000, 16'h0000, 8'h33, 4'h5, 1'b1);
      look(32'h0200_0000, res);
      chk("R7 R10 outside aperture misses", res, pack_res(0, 1, 4'hF, 8'h00, 32'h0));

      // R11 idle hold
      @(negedge clk);
      chk("R11 idle cycle holds result", {59'h0, out_valid, out_tgt},
          {59'h0, 1'b0, 4'hF});

      // random phase
      for (int w = 0; w < NW; w++) set_win(w, 16'h0, 16'h0, 16'h0, 8'h0, 4'h0, 1'b0);
      set_apt(16'h0000, 16'hFFFF, 1'b1);
      for (int it = 0; it < 60; it++) begin
         int w;
         int k;
         logic [15:0] mk, bs;
         w  = int'($urandom % NW);
         k  = int'($urandom % 17);
         mk = 16'((32'd1 << k) - 32'd1);
         bs = 16'($urandom) & ~mk;
         if (($urandom % 8) == 0 && mk != 16'h0) bs[0] = 1'b1;
         set_win(w, mk, bs, 16'($urandom), 8'($urandom), 4'($urandom % 15),
                 ($urandom % 4) != 0);
         if ((it % 10) == 9) begin
            logic [15:0] sz;
            sz = 16'($urandom) >> ($urandom % 16);
            set_apt(16'($urandom) & ~cover_pow2(sz), sz, ($urandom % 5) != 0);
         end
         for (int j = 0; j < 6; j++) begin
            int t;
            logic [31:0] a;
            t = int'($urandom % NW);
            a = {m_base[t] | (16'($urandom) & m_mask[t]), 16'($urandom)};
            if (($urandom % 4) == 0) a = $urandom;
            look_chk("R4 R5 R6 R7 R10 random lookup", a);
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule